// File: doc/BRIEF.md
# Eight-Pin I/O Port with Prioritised Alternate-Function Mux

This block is a byte-wide I/O port controlled through a small register bus. Every pin has a stored output bit and a direction bit; when a pin is set as an output and nothing else has claimed it, the stored bit drives the pad. All pad inputs pass through a two-stage synchronizer. A read-only pin register returns the synchronized pad levels at all times. Software can compare it with the driven value to spot a pin that is shorted or overloaded.

Pins 1 and 0 are shared with peripherals. A serial transmit/receive pair and two PWM channels can take them over. Each of these pins has a fixed three-level ownership order: serial first, then PWM, then plain I/O. Pin 1 carries serial transmit or PWM channel 7. Pin 0 carries serial receive or PWM channel 6. The peripherals supply their enables and output levels on dedicated ports. The serial receiver gets the synchronized pin 0 level back.

Top module: `gpio_mux_port`

## Requirements
- R1: Reset clears the stored output bits and the direction bits to 0, so every pad output enable is 0 after reset unless a peripheral owns the pin.
- R2: A pin that is not owned by a peripheral, with its direction bit at 1, has its output enable at 1 and drives its stored output bit. With the direction bit at 0, its output enable is 0.
- R3: A read of address 0 returns, bit by bit, the stored output bit where the direction bit is 1 and the synchronized pad level where it is 0. Address 1 reads and writes the direction bits.
- R4: A read of address 2 returns the pad levels sampled through two clock edges, whatever the direction and ownership settings.
- R5: A write to address 2 or address 3 changes neither the stored output bits nor the direction bits. Address 3 reads as 0.
- R6: Reset leaves the pin register alone: during and right after reset, address 2 still returns the synchronized pad levels.
- R7: While the serial enable is 1, pin 1 has its output enable at 1 and drives the serial transmit level, whatever the PWM enables and the register settings.
- R8: While the serial enable is 1, pin 0 has its output enable at 0 and drives 0. The serial receive output always equals bit 0 of the synchronized pad levels.
- R9: While the serial enable is 0, PWM enable bit 1 gives pin 1 to PWM level bit 1, and PWM enable bit 0 gives pin 0 to PWM level bit 0. An owned pin has its output enable at 1.
- R10: Pins 7 to 2 behave as in R2 whatever the serial and PWM enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 2 | Register select: 0 output bits, 1 direction, 2 pin levels, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| ser_en | input | 1 | Serial function enable |
| ser_tx | input | 1 | Serial transmit level |
| ser_rx | output | 1 | Synchronized receive level from pin 0 |
| pwm_en | input | 2 | PWM enables: bit 1 channel 7 (pin 1), bit 0 channel 6 (pin 0) |
| pwm_out | input | 2 | PWM levels: bit 1 channel 7, bit 0 channel 6 |

## Verification
A register write to the output or direction bits can land in the same cycle that a serial or PWM enable rises or falls on a shared pin. The random stimulus changes enables, pad levels and both registers together in every iteration. A directed sequence writes the output bit while the serial function owns pin 1, then drops ownership. The bench predicts that the pad follows the owner while the enable is high. Once ownership drops, the bench expects the newly stored bit to appear on the pad.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_PWM  = 2'd1,
    OWN_SER  = 2'd2
  } owner_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  // Deliberately not reset: the pin view reflects the pads, not stored state.
  always_ff @(posedge clk) begin
    stage_q <= stage_d;
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_lvl,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q
);
  reg_sel_e         sel;
  logic             data_wen;
  logic             dir_wen;
  logic [WIDTH-1:0] data_d;
  logic [WIDTH-1:0] dir_d;

  assign sel = reg_sel_e'(bus_addr);

  always_comb begin
    data_wen = bus_we && (sel == SEL_DATA);
    dir_wen  = bus_we && (sel == SEL_DIR);
    data_d   = data_wen ? bus_wdata : data_q;
    dir_d    = dir_wen  ? bus_wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = (data_q & dir_q) | (pin_lvl & ~dir_q);
      SEL_DIR:  bus_rdata = dir_q;
      SEL_PIN:  bus_rdata = pin_lvl;
      default:  bus_rdata = '0;
    endcase
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (data_q == '0) && (dir_q == '0));

  // R5
  pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[1]) |=> $stable(data_q) && $stable(dir_q));

  // R3
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> data_q == $past(bus_wdata));
endmodule

// File: rtl/pin_owner.sv
module pin_owner
  import gpio_port_pkg::*;
#(
  parameter bit SER_DRIVES = 1'b1
) (
  input  logic ser_en,
  input  logic ser_level,
  input  logic pwm_en,
  input  logic pwm_level,
  input  logic gpio_dir,
  input  logic gpio_data,
  output logic pad_oe,
  output logic pad_out
);
  owner_e owner;

  always_comb begin
    if (ser_en)      owner = OWN_SER;
    else if (pwm_en) owner = OWN_PWM;
    else             owner = OWN_GPIO;
  end

  always_comb begin
    unique case (owner)
      OWN_SER: begin
        pad_oe  = SER_DRIVES;
        pad_out = ser_level;
      end
      OWN_PWM: begin
        pad_oe  = 1'b1;
        pad_out = pwm_level;
      end
      default: begin
        pad_oe  = gpio_dir;
        pad_out = gpio_data;
      end
    endcase
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic              ser_en,
  input  logic              ser_tx,
  output logic              ser_rx,
  input  logic [1:0]        pwm_en,
  input  logic [1:0]        pwm_out
);
  localparam int unsigned SHARED = 2;

  logic [WIDTH-1:0] pin_lvl;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;

  pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (pad_in),
    .sync_out (pin_lvl)
  );

  port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_lvl   (pin_lvl),
    .bus_rdata (bus_rdata),
    .data_q    (data_q),
    .dir_q     (dir_q)
  );

  assign ser_rx = pin_lvl[0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < SHARED) begin : g_shared
      pin_owner #(.SER_DRIVES(i == 1)) u_owner (
        .ser_en    (ser_en),
        .ser_level ((i == 1) ? ser_tx : 1'b0),
        .pwm_en    (pwm_en[i]),
        .pwm_level (pwm_out[i]),
        .gpio_dir  (dir_q[i]),
        .gpio_data (data_q[i]),
        .pad_oe    (pad_oe[i]),
        .pad_out   (pad_out[i])
      );
    end else begin : g_plain
      assign pad_oe[i]  = dir_q[i];
      assign pad_out[i] = data_q[i];
    end
  end

  // R7
  ser_tx_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> pad_oe[1] && (pad_out[1] == ser_tx));

  // R8
  ser_rx_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !pad_oe[0] && !pad_out[0]);

  // R9
  pwm_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && pwm_en[0]) |-> pad_oe[0] && (pad_out[0] == pwm_out[0]));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R4
    pin_view_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2) |-> bus_rdata == $past(pad_in, 2));
  end
endmodule

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic       ser_en;
  logic       ser_tx;
  logic       ser_rx;
  logic [1:0] pwm_en;
  logic [1:0] pwm_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_data;
  logic [7:0] m_dir;

  always #5 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ser_en(ser_en), .ser_tx(ser_tx),
    .ser_rx(ser_rx), .pwm_en(pwm_en), .pwm_out(pwm_out)
  );

  function automatic logic [7:0] f_oe(logic [7:0] dir, logic se, logic [1:0] pe);
    logic [7:0] r = dir;
    if (se)         begin r[1] = 1'b1; r[0] = 1'b0; end
    else begin
      if (pe[1]) r[1] = 1'b1;
      if (pe[0]) r[0] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [7:0] f_out(logic [7:0] dat, logic se, logic tx,
                                       logic [1:0] pe, logic [1:0] pv);
    logic [7:0] r = dat;
    if (se) begin r[1] = tx; r[0] = 1'b0; end
    else begin
      if (pe[1]) r[1] = pv[1];
      if (pe[0]) r[0] = pv[0];
    end
    return r;
  endfunction

  function automatic logic [7:0] f_rd0(logic [7:0] dat, logic [7:0] dir, logic [7:0] pin);
    return (dat & dir) | (pin & ~dir);
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
    if (a == 2'd0) m_data = d;
    if (a == 2'd1) m_dir  = d;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] rd;
    #1;
    chk({tag, " R2/R7/R9/R10 oe"}, pad_oe, f_oe(m_dir, ser_en, pwm_en));
    chk({tag, " R2/R7/R9/R10 out"}, pad_out, f_out(m_data, ser_en, ser_tx, pwm_en, pwm_out));
    chk({tag, " R8 rx"}, {7'd0, ser_rx}, {7'd0, pad_in[0]});
    bus_read(2'd0, rd);
    chk({tag, " R3 data read"}, rd, f_rd0(m_data, m_dir, pad_in));
    bus_read(2'd2, rd);
    chk({tag, " R4 pin view"}, rd, pad_in);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pad_in = 8'hA5; ser_en = 1'b0; ser_tx = 1'b0; pwm_en = '0; pwm_out = '0;
    m_data = '0; m_dir = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    #1 chk("R1 oe after reset", pad_oe, 8'h00);
    bus_read(2'd1, rd);
    chk("R1 dir after reset", rd, 8'h00);
    bus_read(2'd0, rd);
    chk("R1 data read as pins", rd, 8'hA5);

    // R2 / R3 directed
    bus_write(2'd0, 8'h3C);
    bus_write(2'd1, 8'hF0);
    settle();
    check_all("dir-mix");
    bus_read(2'd1, rd);
    chk("R3 dir readback", rd, 8'hF0);

    // R5: writes to addresses 2 and 3 ignored
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'h0F);
    m_data = 8'h3C; m_dir = 8'hF0;
    bus_read(2'd1, rd);
    chk("R5 dir kept", rd, 8'hF0);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd0, rd);
    chk("R5 data kept", rd, 8'h3C);
    bus_read(2'd3, rd);
    chk("R5 addr3 reads 0", rd, 8'h00);

    // R7 with concurrent data write, then release
    @(negedge clk); ser_en = 1'b1; ser_tx = 1'b1; pwm_en = 2'b11; pwm_out = 2'b00;
    bus_write(2'd0, 8'h00);
    settle();
    check_all("R7 ser owns");
    @(negedge clk); ser_en = 1'b0; pwm_en = 2'b00;
    #1 chk("R7 release shows new data", pad_out, 8'h00);
    chk("R2 release oe", pad_oe, 8'hFF);

    // R9 PWM over GPIO
    @(negedge clk); pwm_en = 2'b01; pwm_out = 2'b11;
    check_all("R9 pwm6");

    // R6: reset leaves pin view
    @(negedge clk); pad_in = 8'h5A;
    settle();
    @(negedge clk) rst_n = 1'b0;
    #1 bus_addr = 2'd2;
    #1 chk("R6 pin view during reset", bus_rdata, 8'h5A);
    @(negedge clk) rst_n = 1'b1;
    m_data = '0; m_dir = '0;
    bus_read(2'd2, rd);
    chk("R6 pin view after reset", rd, 8'h5A);
    pwm_en = 2'b00;
    check_all("R1 post-reset");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      @(negedge clk);
      pad_in  = 8'($urandom);
      ser_en  = ($urandom % 3) == 0;
      ser_tx  = 1'($urandom);
      pwm_en  = 2'($urandom);
      pwm_out = 2'($urandom);
      bus_write(2'd0, 8'($urandom));
      bus_write(2'd1, 8'($urandom));
      if (($urandom % 4) == 0) bus_write(2'(2 + ($urandom % 2)), 8'($urandom));
      settle();
      check_all("rand");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule